// File: doc/BRIEF.md
# Transfer Descriptor Completion Writeback

This block finishes one general transfer descriptor of a USB host controller once its bus transaction is over. It takes the descriptor's control word, buffer pointer and next-link word, the owning endpoint's head-pointer word, the descriptor's own address and the transaction outcome. The outcome is either a byte count or one of five failure kinds. One clock later the block returns the words to write back to memory. It also says whether the descriptor is written at all, whether it is retired, and whether the endpoint should stop being serviced.

Two pieces of state are kept inside the block. The first is the done-queue head: retired descriptors are pushed onto it in LIFO order through their next-link field. The second is a 3-bit countdown of frames left before a done interrupt. Each retirement can only shorten this countdown. A re-arm input, pulsed by the frame logic once the queue has been handed to software, returns it to its idle value of 7. Memory access, the list walk and the packet transfer itself are handled elsewhere.

Top module: `td_writeback`

## Requirements
- R1: After reset, the done-queue head is 0, the countdown is 7 and `out_valid` is low.
- R2: Success means `res_kind`=0 (data) and either the count equals `pkt_len`, or `eff_dir`=2 (IN) with the rounding flag (control bit 18) set. On success, control bit 25 is set, bit 24 is inverted, the condition code (bits 31:28) becomes 0 and the error count (bits 27:26) becomes 0.
- R3: A success on a non-IN transfer whose count differs from `total_len` writes the descriptor back (`td_write`=1) without retiring it. The head word and the done-queue state are left unchanged.
- R4: On a successful retirement, head bit 1 becomes the new value of control bit 24.
- R5: A data result that does not meet the success rule gives condition code 9.
- R6: For `res_kind` values, STALL (2) gives code 4, BABBLE (3) gives code 8, and IOERROR (4) or NODEV (5) give code 5. Any other failure (6 or 7) gives code 7 and forces the error count to 3.
- R7: A NAK (`res_kind`=1) passes every word through unchanged. It asserts neither `td_write`, `retire` nor `err`, and leaves the done-queue head and countdown untouched.
- R8: Every failure other than NAK sets head bit 0 and retires the descriptor.
- R9: On retirement, head bits 31:4 take the next-link bits 31:4, the next-link output takes the previous done-queue head, and the done-queue head takes `td_addr`.
- R10: On retirement, the countdown becomes the delay field (control bits 23:21) if that is smaller, or 0 if the final code is non-zero. A `dly_rearm` pulse loads 7 before the retirement in that same cycle is applied.
- R11: When the count equals `total_len` on a success, the buffer pointer output is 0. Otherwise it equals the input.
- R12: `err` is high exactly when the descriptor is written with a non-zero condition code.
- R13: All results appear one clock after `req_valid`, with `out_valid` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Completion request this cycle |
| ctrl_in | input | 32 | Descriptor control word |
| cbp_in | input | 32 | Descriptor current buffer pointer |
| next_in | input | 32 | Descriptor next-link word |
| head_in | input | 32 | Endpoint head-pointer word |
| td_addr | input | 32 | Address of this descriptor |
| eff_dir | input | 2 | Resolved direction: 0 setup, 1 out, 2 in |
| res_kind | input | 3 | 0 data, 1 NAK, 2 STALL, 3 BABBLE, 4 IOERROR, 5 NODEV, 6-7 other |
| res_count | input | CNT_W | Bytes moved (data result) |
| pkt_len | input | CNT_W | Bytes attempted in this packet |
| total_len | input | CNT_W | Bytes left in the descriptor buffer |
| dly_rearm | input | 1 | Reload the countdown to 7 |
| out_valid | output | 1 | Results valid |
| ctrl_out | output | 32 | Updated control word |
| cbp_out | output | 32 | Updated buffer pointer |
| next_out | output | 32 | Updated next-link word |
| head_out | output | 32 | Updated endpoint head word |
| retire | output | 1 | Descriptor moved to the done queue |
| td_write | output | 1 | Descriptor must be written back |
| err | output | 1 | Non-zero completion code; stop the endpoint |
| done_head | output | 32 | Done-queue head register |
| done_cnt | output | 3 | Done-interrupt countdown |

## Verification
A re-arm and a retirement can fall in the same cycle, and each one writes the countdown. The bench pulses `dly_rearm` with a successful retirement whose delay field is 5 and expects 5. It then pulses it with a failing retirement and expects 0, since the re-arm must be applied first. Back-to-back retirements also land in consecutive cycles. There, each next-link output must carry the address pushed one cycle before it.

// File: rtl/xdw_pkg.sv
package xdw_pkg;
  localparam int WORD_W = 32;
  // control word field positions (decoded by software)
  localparam int CC_LSB  = 28;
  localparam int EC_LSB  = 26;
  localparam int TGL_HI  = 25;
  localparam int TGL_LO  = 24;
  localparam int DLY_LSB = 21;
  localparam int RND_BIT = 18;
  // head word flag bits
  localparam int HALT_BIT  = 0;
  localparam int CARRY_BIT = 1;
  localparam int LINK_LSB  = 4;

  localparam logic [1:0] DIR_IN = 2'd2;

  localparam logic [2:0] RES_DATA   = 3'd0;
  localparam logic [2:0] RES_NAK    = 3'd1;
  localparam logic [2:0] RES_STALL  = 3'd2;
  localparam logic [2:0] RES_BABBLE = 3'd3;
  localparam logic [2:0] RES_IOERR  = 3'd4;
  localparam logic [2:0] RES_NODEV  = 3'd5;

  localparam logic [3:0] CC_OK       = 4'h0;
  localparam logic [3:0] CC_STALL    = 4'h4;
  localparam logic [3:0] CC_NORESP   = 4'h5;
  localparam logic [3:0] CC_BADPID   = 4'h7;
  localparam logic [3:0] CC_OVERRUN  = 4'h8;
  localparam logic [3:0] CC_UNDERRUN = 4'h9;

  localparam logic [2:0] DLY_IDLE = 3'd7;

  typedef struct packed {
    logic       success;
    logic       nak;
    logic       retire;
    logic       force_ec;
    logic [3:0] cc;
  } verdict_t;
endpackage

// File: rtl/xdw_outcome.sv
module xdw_outcome
  import xdw_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic [2:0]       res_kind,
  input  logic [CNT_W-1:0] res_count,
  input  logic [CNT_W-1:0] pkt_len,
  input  logic [CNT_W-1:0] total_len,
  input  logic [1:0]       eff_dir,
  input  logic             rnd,
  output verdict_t         vrd
);
  logic is_in;
  logic is_data;
  logic partial;

  always_comb begin
    is_in       = (eff_dir == DIR_IN);
    is_data     = (res_kind == RES_DATA);
    vrd         = '0;
    vrd.nak     = (res_kind == RES_NAK);
    vrd.success = is_data && ((res_count == pkt_len) || (is_in && rnd));
    partial     = vrd.success && !is_in && (res_count != total_len);
    vrd.retire  = !vrd.nak && !partial;
    case (res_kind)
      RES_DATA:             vrd.cc = vrd.success ? CC_OK : CC_UNDERRUN;
      RES_NAK:              vrd.cc = CC_OK;
      RES_STALL:            vrd.cc = CC_STALL;
      RES_BABBLE:           vrd.cc = CC_OVERRUN;
      RES_IOERR, RES_NODEV: vrd.cc = CC_NORESP;
      default: begin
        vrd.cc       = CC_BADPID;
        vrd.force_ec = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/xdw_update.sv
module xdw_update
  import xdw_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  verdict_t          vrd,
  input  logic [CNT_W-1:0]  res_count,
  input  logic [CNT_W-1:0]  total_len,
  input  logic [WORD_W-1:0] ctrl_in,
  input  logic [WORD_W-1:0] cbp_in,
  input  logic [WORD_W-1:0] next_in,
  input  logic [WORD_W-1:0] head_in,
  input  logic [WORD_W-1:0] done_head_q,
  output logic [WORD_W-1:0] ctrl_n,
  output logic [WORD_W-1:0] cbp_n,
  output logic [WORD_W-1:0] next_n,
  output logic [WORD_W-1:0] head_n
);
  always_comb begin
    ctrl_n = ctrl_in;
    if (!vrd.nak) begin
      ctrl_n[CC_LSB+:4] = vrd.cc;
      if (vrd.success) begin
        ctrl_n[TGL_HI]    = 1'b1;
        ctrl_n[TGL_LO]    = ~ctrl_in[TGL_LO];
        ctrl_n[EC_LSB+:2] = 2'b00;
      end else if (vrd.force_ec) begin
        ctrl_n[EC_LSB+:2] = 2'b11;
      end
    end

    head_n = head_in;
    if (!vrd.nak && !vrd.success) head_n[HALT_BIT] = 1'b1;
    if (vrd.retire && vrd.success) head_n[CARRY_BIT] = ctrl_n[TGL_LO];
    if (vrd.retire) head_n[WORD_W-1:LINK_LSB] = next_in[WORD_W-1:LINK_LSB];

    next_n = vrd.retire ? done_head_q : next_in;
    cbp_n  = (vrd.success && (res_count == total_len)) ? '0 : cbp_in;
  end
endmodule

// File: rtl/xdw_doneq.sv
module xdw_doneq
  import xdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_addr,
  input  logic [2:0]        push_dly,
  input  logic              push_err,
  input  logic              rearm,
  output logic [WORD_W-1:0] head_q,
  output logic [2:0]        cnt_q
);
  logic [WORD_W-1:0] head_d;
  logic [2:0]        cnt_d;
  logic [2:0]        base;

  always_comb begin
    base   = rearm ? DLY_IDLE : cnt_q;
    cnt_d  = base;
    head_d = head_q;
    if (push) begin
      head_d = push_addr;
      if (push_err)           cnt_d = 3'd0;
      else if (push_dly < base) cnt_d = push_dly;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= DLY_IDLE;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  // R9
  head_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> head_q == $past(push_addr));
  // R10
  cnt_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_err) |=> cnt_q == 3'd0);
  // R10
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rearm |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/td_writeback.sv
module td_writeback
  import xdw_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       ctrl_in,
  input  logic [31:0]       cbp_in,
  input  logic [31:0]       next_in,
  input  logic [31:0]       head_in,
  input  logic [31:0]       td_addr,
  input  logic [1:0]        eff_dir,
  input  logic [2:0]        res_kind,
  input  logic [CNT_W-1:0]  res_count,
  input  logic [CNT_W-1:0]  pkt_len,
  input  logic [CNT_W-1:0]  total_len,
  input  logic              dly_rearm,
  output logic              out_valid,
  output logic [31:0]       ctrl_out,
  output logic [31:0]       cbp_out,
  output logic [31:0]       next_out,
  output logic [31:0]       head_out,
  output logic              retire,
  output logic              td_write,
  output logic              err,
  output logic [31:0]       done_head,
  output logic [2:0]        done_cnt
);
  verdict_t          vrd;
  logic [WORD_W-1:0] ctrl_n, cbp_n, next_n, head_n;
  logic              err_n;
  logic              push;

  xdw_outcome #(.CNT_W(CNT_W)) outcome_i (
    .res_kind (res_kind),
    .res_count(res_count),
    .pkt_len  (pkt_len),
    .total_len(total_len),
    .eff_dir  (eff_dir),
    .rnd      (ctrl_in[RND_BIT]),
    .vrd      (vrd)
  );

  xdw_update #(.CNT_W(CNT_W)) update_i (
    .vrd        (vrd),
    .res_count  (res_count),
    .total_len  (total_len),
    .ctrl_in    (ctrl_in),
    .cbp_in     (cbp_in),
    .next_in    (next_in),
    .head_in    (head_in),
    .done_head_q(done_head),
    .ctrl_n     (ctrl_n),
    .cbp_n      (cbp_n),
    .next_n     (next_n),
    .head_n     (head_n)
  );

  assign push  = req_valid && vrd.retire;
  assign err_n = !vrd.nak && (vrd.cc != CC_OK);

  xdw_doneq doneq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_addr(td_addr),
    .push_dly (ctrl_in[DLY_LSB+:3]),
    .push_err (err_n),
    .rearm    (dly_rearm),
    .head_q   (done_head),
    .cnt_q    (done_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_out <= '0;
      cbp_out  <= '0;
      next_out <= '0;
      head_out <= '0;
      retire   <= 1'b0;
      td_write <= 1'b0;
      err      <= 1'b0;
    end else if (req_valid) begin
      ctrl_out <= ctrl_n;
      cbp_out  <= cbp_n;
      next_out <= next_n;
      head_out <= head_n;
      retire   <= vrd.retire;
      td_write <= !vrd.nak;
      err      <= err_n;
    end
  end

  // R8
  halt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> (head_out[HALT_BIT] && retire));
  // R7
  nak_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && res_kind == RES_NAK) |=>
      (!retire && !td_write && ctrl_out == $past(ctrl_in) && $stable(done_head)));
  // R2
  ok_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && td_write && !err) |-> (ctrl_out[TGL_HI] && ctrl_out[EC_LSB+:2] == 2'b00));
  // R13
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R9
  link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && retire) |-> head_out[31:4] == $past(next_in[31:4]));
endmodule

// File: tb/td_writeback_tb_top.sv
`timescale 1ns/1ps
module td_writeback_tb_top;
  localparam int CNT_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] ctrl_in = '0, cbp_in = '0, next_in = '0, head_in = '0, td_addr = '0;
  logic [1:0]  eff_dir = '0;
  logic [2:0]  res_kind = '0;
  logic [CNT_W-1:0] res_count = '0, pkt_len = '0, total_len = '0;
  logic dly_rearm = 1'b0;
  logic out_valid, retire, td_write, err;
  logic [31:0] ctrl_out, cbp_out, next_out, head_out, done_head;
  logic [2:0]  done_cnt;

  always #2 clk = ~clk;

  td_writeback #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ctrl_in(ctrl_in),
    .cbp_in(cbp_in), .next_in(next_in), .head_in(head_in), .td_addr(td_addr),
    .eff_dir(eff_dir), .res_kind(res_kind), .res_count(res_count),
    .pkt_len(pkt_len), .total_len(total_len), .dly_rearm(dly_rearm),
    .out_valid(out_valid), .ctrl_out(ctrl_out), .cbp_out(cbp_out),
    .next_out(next_out), .head_out(head_out), .retire(retire),
    .td_write(td_write), .err(err), .done_head(done_head), .done_cnt(done_cnt)
  );

  typedef struct {
    string       tag;
    logic [31:0] ctrl, cbp, nxt, head, dh;
    logic        ret, wb, er;
    logic [2:0]  dc;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  logic [31:0] m_head = '0;
  logic [2:0]  m_cnt = 3'd7;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(logic t0, logic rnd, logic [2:0] dly);
    logic [31:0] c = 32'h0;
    c[24] = t0; c[18] = rnd; c[23:21] = dly;
    c[31:28] = 4'hF; c[27:26] = 2'b01;
    return c;
  endfunction

  // driver: called at a negedge; presents one request and models the expectation
  task automatic send(string tag, logic [31:0] c, logic [31:0] cbp, logic [31:0] nx,
                      logic [31:0] hd, logic [31:0] addr, logic [1:0] dir,
                      logic [2:0] kind, int cnt, int plen, int tlen, logic rearm);
    exp_t e;
    logic is_in, succ, part, ret, nak;
    logic [3:0] cc;
    logic [2:0] base;
    is_in = (dir == 2'd2);
    nak   = (kind == 3'd1);
    succ  = (kind == 3'd0) && ((cnt == plen) || (is_in && c[18]));
    part  = succ && !is_in && (cnt != tlen);
    ret   = !nak && !part;
    case (kind)
      3'd0: cc = succ ? 4'h0 : 4'h9;
      3'd1: cc = 4'h0;
      3'd2: cc = 4'h4;
      3'd3: cc = 4'h8;
      3'd4, 3'd5: cc = 4'h5;
      default: cc = 4'h7;
    endcase
    e.tag = tag;
    e.ctrl = c;
    if (!nak) begin
      e.ctrl[31:28] = cc;
      if (succ) begin e.ctrl[25] = 1'b1; e.ctrl[24] = ~c[24]; e.ctrl[27:26] = 2'b00; end
      else if (kind >= 3'd6) e.ctrl[27:26] = 2'b11;
    end
    e.head = hd;
    if (!nak && !succ) e.head[0] = 1'b1;
    if (ret && succ) e.head[1] = e.ctrl[24];
    if (ret) e.head[31:4] = nx[31:4];
    e.cbp = (succ && cnt == tlen) ? 32'h0 : cbp;
    e.nxt = ret ? m_head : nx;
    base = rearm ? 3'd7 : m_cnt;
    if (ret) begin
      if (cc != 4'h0) base = 3'd0;
      else if (c[23:21] < base) base = c[23:21];
      m_head = addr;
    end
    m_cnt = base;
    e.dh = m_head; e.dc = m_cnt;
    e.ret = ret; e.wb = !nak; e.er = !nak && (cc != 4'h0);
    q.push_back(e);
    req_valid = 1'b1; ctrl_in = c; cbp_in = cbp; next_in = nx; head_in = hd;
    td_addr = addr; eff_dir = dir; res_kind = kind; res_count = cnt[CNT_W-1:0];
    pkt_len = plen[CNT_W-1:0]; total_len = tlen[CNT_W-1:0]; dly_rearm = rearm;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0; dly_rearm = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard compare at the negedge after the capturing edge (R13)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R13 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "ctrl_out", ctrl_out, e.ctrl);
        chk(e.tag, "cbp_out", cbp_out, e.cbp);
        chk(e.tag, "next_out", next_out, e.nxt);
        chk(e.tag, "head_out", head_out, e.head);
        chk(e.tag, "retire", {31'b0, retire}, {31'b0, e.ret});
        chk(e.tag, "td_write", {31'b0, td_write}, {31'b0, e.wb});
        chk(e.tag, "err", {31'b0, err}, {31'b0, e.er});
        chk(e.tag, "done_head", done_head, e.dh);
        chk(e.tag, "done_cnt", {29'b0, done_cnt}, {29'b0, e.dc});
      end
    end
  end

  initial begin
    #(4 * 5000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done_head", done_head, 32'h0);
    chk("R1", "done_cnt", {29'b0, done_cnt}, 32'd7);
    chk("R1", "out_valid", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R4 R11: full OUT success, back to back with R9 IN rounding short packet
    send("R2_R4_R11", mk_ctrl(1'b0, 1'b0, 3'd3), 32'h0000_5040, 32'h2000_0000,
         32'h3000_0000, 32'h0000_1000, 2'd1, 3'd0, 64, 64, 64, 1'b0);
    send("R9_R2_R4", mk_ctrl(1'b1, 1'b1, 3'd6), 32'h0000_6000, 32'h2100_0005,
         32'h3100_0006, 32'h0000_1100, 2'd2, 3'd0, 5, 64, 64, 1'b0);
    // R3 partial OUT success
    send("R3", mk_ctrl(1'b0, 1'b0, 3'd1), 32'h0000_7000, 32'h2200_0000,
         32'h3200_0000, 32'h0000_1200, 2'd0, 3'd0, 16, 16, 64, 1'b0);
    idle(1);
    // R5 IN short without rounding -> underrun, halted
    send("R5_R8_R12", mk_ctrl(1'b0, 1'b0, 3'd7), 32'h0000_8000, 32'h2300_0000,
         32'h3300_0000, 32'h0000_1300, 2'd2, 3'd0, 3, 64, 64, 1'b0);
    // R6 error code mapping
    send("R6_stall", mk_ctrl(1'b1, 1'b0, 3'd7), 32'h1, 32'h2400_0000, 32'h3400_0002,
         32'h0000_1400, 2'd1, 3'd2, 0, 8, 8, 1'b1);
    send("R6_babble", mk_ctrl(1'b0, 1'b0, 3'd7), 32'h2, 32'h2500_0000, 32'h0,
         32'h0000_1500, 2'd2, 3'd3, 0, 8, 8, 1'b0);
    send("R6_ioerr", mk_ctrl(1'b0, 1'b0, 3'd7), 32'h3, 32'h2600_0000, 32'h0,
         32'h0000_1600, 2'd1, 3'd4, 0, 8, 8, 1'b0);
    send("R6_nodev", mk_ctrl(1'b0, 1'b0, 3'd7), 32'h4, 32'h2700_0000, 32'h0,
         32'h0000_1700, 2'd1, 3'd5, 0, 8, 8, 1'b0);
    send("R6_other6", mk_ctrl(1'b0, 1'b0, 3'd7), 32'h5, 32'h2800_0000, 32'h0,
         32'h0000_1800, 2'd1, 3'd6, 0, 8, 8, 1'b0);
    send("R6_other7", mk_ctrl(1'b0, 1'b0, 3'd7), 32'h6, 32'h2900_0000, 32'h0,
         32'h0000_1900, 2'd0, 3'd7, 0, 8, 8, 1'b0);
    idle(1);
    // R7 NAK leaves everything as it was
    send("R7", mk_ctrl(1'b1, 1'b1, 3'd0), 32'h0000_ABC0, 32'h2A00_0007,
         32'h3A00_0001, 32'h0000_1A00, 2'd2, 3'd1, 0, 8, 8, 1'b0);
    idle(1);
    // R10 re-arm alone restores 7
    dly_rearm = 1'b1;
    m_cnt = 3'd7;
    @(negedge clk);
    dly_rearm = 1'b0;
    chk("R10", "done_cnt after rearm", {29'b0, done_cnt}, 32'd7);
    // R10 min tracking, then same-cycle rearm with success and with failure
    send("R10_min", mk_ctrl(1'b0, 1'b0, 3'd2), 32'h0, 32'h2B00_0000, 32'h0,
         32'h0000_1B00, 2'd1, 3'd0, 4, 4, 4, 1'b0);
    send("R10_rearm_ok", mk_ctrl(1'b0, 1'b0, 3'd5), 32'h0, 32'h2C00_0000, 32'h0,
         32'h0000_1C00, 2'd1, 3'd0, 4, 4, 4, 1'b1);
    send("R10_keep", mk_ctrl(1'b0, 1'b0, 3'd6), 32'h0, 32'h2D00_0000, 32'h0,
         32'h0000_1D00, 2'd1, 3'd0, 4, 4, 4, 1'b0);
    send("R10_rearm_err", mk_ctrl(1'b0, 1'b0, 3'd5), 32'h0, 32'h2E00_0000, 32'h0,
         32'h0000_1E00, 2'd1, 3'd2, 0, 4, 4, 1'b1);
    idle(3);
    chk("R13", "scoreboard drained", q.size(), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule